// File: doc/BRIEF.md
# Dual Output Compare Unit with Atomic Byte Writes

This block keeps two 16-bit compare values, one for channel A and one for channel B. It watches a free-running 16-bit counter that sits outside the block. A processor loads each compare value over an 8-bit bus. A single shared holding byte collects the upper half of a value. The lower-half write then commits all 16 bits in one clock edge, so the comparator never sees a value that is half old and half new.

A channel raises its match flag only when the counter steps onto the compare value by a normal increment. A software load of the counter does not raise it, and neither does a rewrite of the compare value, even when that leaves the two equal. The flag becomes visible in the cycle after the counting event and stays up until software clears it. Each channel's flag is a two-state machine. `FLG_IDLE` moves to `FLG_PEND` on a qualified hit. `FLG_PEND` moves back to `FLG_IDLE` on a clear strobe that arrives without a simultaneous hit. In every other case the state holds.

Top module: `ocu_dual_cmp`

## Requirements
- R1: After reset both compare values read zero and both flags are low.
- R2: A write with `wr_addr[0]`=1 (upper byte) stores `wr_data` only in the shared holding byte. Neither compare value changes.
- R3: A write with `wr_addr[0]`=0 (lower byte) to the channel selected by `wr_addr[1]` (0 = A, 1 = B) loads {holding byte, `wr_data`} into that compare value at one edge. The new value is readable in the next cycle.
- R4: Both channels share one holding byte, so the last upper-byte write to either channel supplies the upper half of the next commit.
- R5: `rd_data` returns the committed byte chosen by `rd_addr`, using the same encoding as `wr_addr`. It never returns the holding byte.
- R6: In a cycle where `cnt_tick`=1, `cnt_load`=0 and `cnt_val` equals a channel's compare value, that channel's flag is high from the next cycle on.
- R7: No flag is raised when `cnt_load`=1, even if `cnt_tick`=1 and the values are equal. No flag is raised when a compare-value write alone makes the two equal.
- R8: A set flag stays high until its `clr` bit is 1 in a cycle with no hit. When a clear and a hit coincide, the flag ends high.
- R9: A hit on one channel never changes the other channel's flag. `flag[0]`/`clr[0]` belong to A, and `flag[1]`/`clr[1]` belong to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Current counter value; when `cnt_tick`=1, the value just counted onto |
| cnt_tick | input | 1 | Counter advanced by normal counting this cycle |
| cnt_load | input | 1 | Counter written by software this cycle |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Bit 1 channel (0 A, 1 B), bit 0 byte (1 upper, 0 lower) |
| wr_data | input | 8 | Write byte |
| clr | input | 2 | Per-channel flag clear strobes |
| rd_addr | input | 2 | Readback select, same encoding as `wr_addr` |
| rd_data | output | 8 | Committed byte selected by `rd_addr` |
| flag | output | 2 | Per-channel match flags |

## Verification
The bench goes after the holding byte first. It checks that an upper-byte write alone leaves readback unchanged, which a design committing on the upper byte would fail. It also crosses the two channels, which catches a design with a private holding byte per channel. A full counting ramp across both compare values catches an off-by-one flag timing or a flag that fires on every equal cycle without a tick. An exhaustive sweep over tick, load, equality, clear and prior flag state exposes a design that matches on a counter load or lets a clear beat a coincident hit. Rewriting a compare value onto a stationary counter exposes a design that compares without looking at the tick.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    localparam int OCU_BUS_W = 8;
    localparam int OCU_N_CH  = 2;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flg_state_t;
endpackage

// File: rtl/ocu_byte_wr.sv
module ocu_byte_wr #(
    parameter int BUS_W = 8,
    parameter int N_CH  = 2,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int AW   = CH_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [BUS_W-1:0]     wr_data,
    output logic [N_CH-1:0]      commit,
    output logic [2*BUS_W-1:0]   commit_val
);
    logic [BUS_W-1:0] hold_q;
    logic             is_upper;
    logic [CH_W-1:0]  sel_ch;

    assign is_upper = wr_addr[0];
    assign sel_ch   = wr_addr[AW-1:1];

    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr_en && is_upper)
            hold_q <= wr_data;
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_dec
            assign commit[c] = wr_en && !is_upper && (sel_ch == CH_W'(c));
        end
    endgenerate

    assign commit_val = {hold_q, wr_data};

    // R2: an upper-byte write lands in the holding byte
    a_r2_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_upper) |=> (hold_q == $past(wr_data)));
    // R4: holding byte survives everything but an upper-byte write
    a_r4_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && is_upper) |=> $stable(hold_q));
endmodule

// File: rtl/ocu_chan.sv
module ocu_chan
    import ocu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_tick,
    input  logic             cnt_load,
    input  logic             clr,
    output logic [CNT_W-1:0] value,
    output logic             flag
);
    logic [CNT_W-1:0] value_q;
    logic             hit;
    flg_state_t       state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= '0;
        else if (commit)
            value_q <= commit_val;
    end

    assign hit = cnt_tick && !cnt_load && (cnt_val == value_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (hit) state_d = FLG_PEND;
            FLG_PEND: if (clr && !hit) state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FLG_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        value = value_q;
        flag  = (state_q == FLG_PEND);
    end

    // R3: a commit shows up whole on the next cycle
    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (value == $past(commit_val)));
    // R2: without a commit the compare value holds
    a_r2_value_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(value));
    // R7: a rising flag needs a counted, non-loaded equal cycle before it
    a_r7_rise_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cnt_tick && !cnt_load));
    // R8: a hit always leaves the flag set, clear or not
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !cnt_load && cnt_val == value) |=> flag);
    // R8: a clear without a hit drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(cnt_tick && !cnt_load && cnt_val == value)) |=> !flag);
endmodule

// File: rtl/ocu_dual_cmp.sv
module ocu_dual_cmp
    import ocu_pkg::*;
#(
    parameter int BUS_W = OCU_BUS_W,
    parameter int N_CH  = OCU_N_CH,
    localparam int CNT_W = 2 * BUS_W,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int AW    = CH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_tick,
    input  logic             cnt_load,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [N_CH-1:0]  clr,
    input  logic [AW-1:0]    rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic [N_CH-1:0]  flag
);
    logic [N_CH-1:0]  commit;
    logic [CNT_W-1:0] commit_val;
    logic [CNT_W-1:0] value [N_CH];
    logic [CH_W-1:0]  rd_ch;

    ocu_byte_wr #(.BUS_W(BUS_W), .N_CH(N_CH)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_val (commit_val)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            ocu_chan #(.CNT_W(CNT_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .commit     (commit[c]),
                .commit_val (commit_val),
                .cnt_val    (cnt_val),
                .cnt_tick   (cnt_tick),
                .cnt_load   (cnt_load),
                .clr        (clr[c]),
                .value      (value[c]),
                .flag       (flag[c])
            );
        end
    endgenerate

    assign rd_ch = rd_addr[AW-1:1];

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (rd_ch == CH_W'(c))
                rd_data = rd_addr[0] ? value[c][CNT_W-1:BUS_W] : value[c][BUS_W-1:0];
        end
    end

    // R3: at most one channel commits per write
    a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit));
endmodule

// File: tb/ocu_dual_cmp_test.sv
module ocu_dual_cmp_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_val;
    logic        cnt_tick, cnt_load, wr_en;
    logic [1:0]  wr_addr, clr, rd_addr, flag;
    logic [7:0]  wr_data, rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_reg [2];
    logic [7:0]  m_hold;
    logic [1:0]  m_flag;

    always #5 clk = ~clk;

    ocu_dual_cmp uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .cnt_load(cnt_load), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data), .flag(flag)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 4; a++) begin
            logic [15:0] r;
            rd_addr = 2'(a);
            #1;
            r = m_reg[a >> 1];
            chk(tag, $sformatf("rd byte %0d", a), {8'h00, rd_data}, {8'h00, (a & 1) ? r[15:8] : r[7:0]});
        end
        chk(tag, "flags", {14'h0, flag}, {14'h0, m_flag});
    endtask

    task automatic step(input logic tk, input logic ld, input logic [15:0] cv,
                        input logic we, input logic [1:0] wa, input logic [7:0] wd,
                        input logic [1:0] cl, input string tag);
        cnt_tick = tk; cnt_load = ld; cnt_val = cv;
        wr_en = we; wr_addr = wa; wr_data = wd; clr = cl;
        for (int c = 0; c < 2; c++) begin
            if (tk && !ld && cv == m_reg[c]) m_flag[c] = 1'b1;
            else if (cl[c]) m_flag[c] = 1'b0;
        end
        if (we) begin
            if (wa[0]) m_hold = wd;
            else m_reg[wa[1]] = {m_hold, wd};
        end
        @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0; cnt_load = 1'b0; wr_en = 1'b0; clr = 2'b00;
        check_all(tag);
    endtask

    task automatic wr16(input logic ch, input logic [15:0] v, input string tag);
        step(0, 0, cnt_val, 1, {ch, 1'b1}, v[15:8], 2'b00, tag);
        step(0, 0, cnt_val, 1, {ch, 1'b0}, v[7:0], 2'b00, tag);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_val = '0; cnt_tick = 0; cnt_load = 0;
        wr_en = 0; wr_addr = '0; wr_data = '0; clr = '0; rd_addr = '0;
        m_reg[0] = '0; m_reg[1] = '0; m_hold = '0; m_flag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2 R3 R5: write sweep, upper byte alone must not move readback
        for (int i = 0; i < 32; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h0809) ^ 16'hA55A;
            for (int ch = 0; ch < 2; ch++) begin
                step(0, 0, 16'h0, 1, {ch[0], 1'b1}, v[15:8] ^ 8'(ch), 2'b00, "R2");
                step(0, 0, 16'h0, 1, {ch[0], 1'b0}, v[7:0], 2'b00, "R3");
            end
        end

        // R4: shared holding byte across channels
        step(0, 0, 16'h0, 1, 2'b01, 8'h12, 2'b00, "R4");
        step(0, 0, 16'h0, 1, 2'b10, 8'h34, 2'b00, "R4");
        chk("R4", "B after cross write", m_reg[1], 16'h1234);
        step(0, 0, 16'h0, 1, 2'b11, 8'h56, 2'b00, "R4");
        step(0, 0, 16'h0, 1, 2'b01, 8'h78, 2'b00, "R5");
        step(0, 0, 16'h0, 1, 2'b00, 8'h9A, 2'b00, "R4");
        chk("R4", "A after overwritten hold", m_reg[0], 16'h789A);

        // R6 R9: counting ramp across both compare values
        wr16(0, 16'h0025, "R6");
        wr16(1, 16'h00F0, "R9");
        for (int n = 0; n < 512; n++) begin
            logic [1:0] c;
            c = m_flag;
            step(1, 0, 16'(n), 0, 2'b00, 8'h00, c, (n == 16'h25 || n == 16'hF0) ? "R6" : "R9");
        end

        // R7: counter load onto equal value, with and without tick
        step(0, 1, 16'h0025, 0, 2'b00, 8'h00, 2'b00, "R7");
        step(1, 1, 16'h0025, 0, 2'b00, 8'h00, 2'b00, "R7");
        // R7: compare value rewritten onto a stationary counter
        step(0, 0, 16'h0300, 0, 2'b00, 8'h00, 2'b00, "R7");
        wr16(0, 16'h0300, "R7");
        step(0, 0, 16'h0300, 0, 2'b00, 8'h00, 2'b00, "R7");
        step(1, 0, 16'h0300, 0, 2'b00, 8'h00, 2'b00, "R6");
        step(0, 0, 16'h0300, 0, 2'b00, 8'h00, 2'b11, "R8");

        // R8: exhaustive tick/load/equal/clear/prior flag on channel A
        for (int k = 0; k < 32; k++) begin
            logic pre, tk, ld, eq, cl;
            {pre, tk, ld, eq, cl} = 5'(k);
            if (pre) step(1, 0, 16'h0300, 0, 2'b00, 8'h00, 2'b00, "R8");
            else     step(0, 0, 16'h0300, 0, 2'b00, 8'h00, 2'b11, "R8");
            step(tk, ld, eq ? 16'h0300 : 16'h0301, 0, 2'b00, 8'h00, {1'b0, cl}, "R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule